// File: doc/BRIEF.md
# Digit-serial GF(2^m) polynomial-basis multiplier

The block multiplies two elements of the binary field GF(2^M) in polynomial basis and reduces the product modulo a field polynomial that is supplied at run time. Multiplicand `a_i`, multiplier `b_i` and the reduction polynomial `f_i` are loaded on a one-cycle `start_i` pulse. The multiplier is then consumed D bits per clock, starting from its most significant digit. On each clock the accumulator is multiplied by x^D and reduced, and the reduced partial product of the current digit with the multiplicand is added to it. When M is not a multiple of D, the top digit is padded with zeros above bit M-1.

The field order M and the digit width D are elaboration parameters. With D = 1 the block is the classic bit-serial, most-significant-bit-first multiplier. Larger D trades a deeper combinational step for fewer cycles. `done_o` marks the cycle in which `c_o` first shows the product, and `c_o` keeps that value until the next start.

Top module: `gf2m_digit_mul`

## Requirements
- R1: Once `done_o` is asserted, `c_o` equals A·B mod F. Here F(x) = x^M + f(x), and bit k of `a_i`, `b_i`, `f_i` and `c_o` is the coefficient of x^k.
- R2: With D = 1 the block returns the same product as the bit-serial multiply-and-reduce recurrence and takes S = M cycles.
- R3: When M is not a multiple of D, the product is still correct, because the top digit is zero-padded above bit M-1.
- R4: `done_o` is high for exactly one cycle. That cycle comes S = ceil(M/D) clock edges after the edge that samples `start_i`.
- R5: Once `done_o` has been asserted, `c_o` keeps its value until the next `start_i`, even while `a_i`, `b_i` and `f_i` change.
- R6: A `start_i` during a running operation abandons it. No `done_o` is produced for the abandoned operation. The new operands are loaded, and their result arrives S edges after the new start.
- R7: After reset, and until the first start, `done_o` is 0 and `c_o` is 0.
- R8: The reduction polynomial is taken from `f_i` at start. The same operands under two different polynomials give the two corresponding products.
- R9: The edge operands behave correctly: A = 1 returns B, and B = 0 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that loads the operands and starts an operation |
| a_i | input | M | Multiplicand A(x) |
| b_i | input | M | Multiplier B(x), consumed most significant digit first |
| f_i | input | M | Low M coefficients of the field polynomial (the x^M term is implied) |
| c_o | output | M | Product A·B mod F |
| done_o | output | 1 | One-cycle flag marking the cycle in which the result first appears |

## Verification
The bench builds a small field instance with M = 5 and D = 2. This instance has three digits and a padded top digit. For it, every pair of operands is swept under two different reduction polynomials, which covers all digit patterns, including the padded one and the restart case. Three M = 163 instances with D = 1, 4 and 8 run on shared random operands, so the bit-serial recurrence, a one-bit pad and a five-bit pad are all compared against an arithmetic model computed in the bench. The same instances check the 163-, 41- and 21-cycle latencies.

// File: rtl/gf2m_mul_pkg.sv
package gf2m_mul_pkg;
  function automatic int unsigned ceil_div(input int unsigned n, input int unsigned d);
    return (n + d - 1) / d;
  endfunction
endpackage

// File: rtl/gf2m_xtime.sv
// Single multiply by x, reduced by x^M = f(x).
module gf2m_xtime #(
  parameter int unsigned M = 163
) (
  input  logic [M-1:0] v_i,
  input  logic [M-1:0] f_i,
  output logic [M-1:0] v_o
);
  assign v_o = {v_i[M-2:0], 1'b0} ^ ({M{v_i[M-1]}} & f_i);
endmodule

// File: rtl/gf2m_shift_reduce.sv
// Multiply by x^D mod F: D folded single-bit shifts.
module gf2m_shift_reduce #(
  parameter int unsigned M = 163,
  parameter int unsigned D = 8
) (
  input  logic [M-1:0] v_i,
  input  logic [M-1:0] f_i,
  output logic [M-1:0] v_o
);
  logic [M-1:0] stage [D+1];

  assign stage[0] = v_i;

  for (genvar k = 0; k < D; k++) begin : g_stage
    gf2m_xtime #(.M(M)) u_xt (
      .v_i (stage[k]),
      .f_i (f_i),
      .v_o (stage[k+1])
    );
  end

  assign v_o = stage[D];
endmodule

// File: rtl/gf2m_digit_pp.sv
// Reduced partial product dig(x)*A(x) mod F as XOR of selected x^j*A mod F.
module gf2m_digit_pp #(
  parameter int unsigned M = 163,
  parameter int unsigned D = 8
) (
  input  logic [M-1:0] a_i,
  input  logic [M-1:0] f_i,
  input  logic [D-1:0] dig_i,
  output logic [M-1:0] pp_o
);
  logic [M-1:0] pow [D];

  assign pow[0] = a_i;

  for (genvar j = 1; j < D; j++) begin : g_pow
    gf2m_xtime #(.M(M)) u_xt (
      .v_i (pow[j-1]),
      .f_i (f_i),
      .v_o (pow[j])
    );
  end

  always_comb begin
    pp_o = '0;
    for (int j = 0; j < D; j++) begin
      if (dig_i[j]) pp_o = pp_o ^ pow[j];
    end
  end
endmodule

// File: rtl/gf2m_digit_mul.sv
module gf2m_digit_mul
  import gf2m_mul_pkg::*;
#(
  parameter int unsigned M = 163,
  parameter int unsigned D = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [M-1:0] a_i,
  input  logic [M-1:0] b_i,
  input  logic [M-1:0] f_i,
  output logic [M-1:0] c_o,
  output logic         done_o
);
  localparam int unsigned S  = ceil_div(M, D);
  localparam int unsigned SW = S * D;
  localparam int unsigned CW = $clog2(S + 1);

  logic [M-1:0]  a_q, f_q, acc_q;
  logic [SW-1:0] b_q, b_ext;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;
  logic [M-1:0]  acc_sh, pp, acc_d;

  // zero-pad top digit above bit M-1
  always_comb begin
    b_ext        = '0;
    b_ext[M-1:0] = b_i;
  end

  gf2m_shift_reduce #(.M(M), .D(D)) u_shift (
    .v_i (acc_q),
    .f_i (f_q),
    .v_o (acc_sh)
  );

  gf2m_digit_pp #(.M(M), .D(D)) u_pp (
    .a_i   (a_q),
    .f_i   (f_q),
    .dig_i (b_q[SW-1 -: D]),
    .pp_o  (pp)
  );

  assign acc_d = acc_sh ^ pp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q    <= '0;
      f_q    <= '0;
      b_q    <= '0;
      acc_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      a_q    <= a_i;
      f_q    <= f_i;
      b_q    <= b_ext;
      acc_q  <= '0;
      cnt_q  <= CW'(S);
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      acc_q <= acc_d;
      b_q   <= b_q << D;
      cnt_q <= cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign c_o    = acc_q;
  assign done_o = done_q;
endmodule

// File: rtl/gf2m_mul_chk.sv
module gf2m_mul_chk
  import gf2m_mul_pkg::*;
#(
  parameter int unsigned M = 163,
  parameter int unsigned D = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic [M-1:0] c_o,
  input logic         done_o
);
  localparam int unsigned S  = ceil_div(M, D);
  localparam int unsigned AW = $clog2(S + 3);

  logic          armed_q;
  logic [AW-1:0] age_q;

  initial begin
    p_param_ok: assert (D >= 1 && D <= M && M >= 2);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      age_q   <= '0;
    end else if (start_i) begin
      armed_q <= 1'b1;
      age_q   <= '0;
    end else if (armed_q && age_q <= AW'(S)) begin
      age_q <= age_q + AW'(1);
    end
  end

  p_done_on_time_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (armed_q && age_q == AW'(S)));

  p_done_due_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && age_q == AW'(S)) |-> done_o);

  p_result_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && age_q == AW'(S + 1)) |-> $stable(c_o));

  p_idle_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |-> (c_o == '0 && !done_o));
endmodule

bind gf2m_digit_mul gf2m_mul_chk #(.M(M), .D(D)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .c_o     (c_o),
  .done_o  (done_o)
);

// File: tb/tb_gf2m_digit_mul.sv
module tb_gf2m_digit_mul;
  localparam int MB = 163;
  localparam int MS = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // large field instances share operands
  logic          start_b = 1'b0;
  logic [MB-1:0] a_b = '0, b_b = '0, f_b = '0;
  logic [MB-1:0] c8, c4, c1;
  logic          dn8, dn4, dn1;

  // small field instance
  logic          start_s = 1'b0;
  logic [MS-1:0] a_s = '0, b_s = '0, f_s = '0;
  logic [MS-1:0] c_s;
  logic          dn_s;

  gf2m_digit_mul #(.M(MB), .D(8)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_b),
    .a_i(a_b), .b_i(b_b), .f_i(f_b), .c_o(c8), .done_o(dn8));
  gf2m_digit_mul #(.M(MB), .D(4)) dut_d4 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_b),
    .a_i(a_b), .b_i(b_b), .f_i(f_b), .c_o(c4), .done_o(dn4));
  gf2m_digit_mul #(.M(MB), .D(1)) dut_d1 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_b),
    .a_i(a_b), .b_i(b_b), .f_i(f_b), .c_o(c1), .done_o(dn1));
  gf2m_digit_mul #(.M(MS), .D(2)) dut_sm (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_s),
    .a_i(a_s), .b_i(b_s), .f_i(f_s), .c_o(c_s), .done_o(dn_s));

  function automatic logic [MB-1:0] ref_mul(input logic [MB-1:0] a, input logic [MB-1:0] b,
                                            input logic [MB-1:0] f, input int m);
    logic [MB-1:0] c, mask;
    logic top;
    mask = (MB'(1) << m) - MB'(1);
    c = '0;
    for (int i = m - 1; i >= 0; i--) begin
      top = c[m-1];
      c = (c << 1) & mask;
      if (top) c = c ^ f;
      if (b[i]) c = c ^ a;
    end
    return c & mask;
  endfunction

  function automatic logic [MB-1:0] rnd_big();
    logic [191:0] w;
    w = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    return w[MB-1:0];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [MB-1:0] act, input logic [MB-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_big(input logic [MB-1:0] a, input logic [MB-1:0] b,
                         input logic [MB-1:0] f, input string req);
    int t8 = -1, t4 = -1, t1 = -1, n8 = 0, n4 = 0, n1 = 0;
    logic [MB-1:0] exp;
    @(negedge clk);
    a_b = a; b_b = b; f_b = f; start_b = 1'b1;
    @(negedge clk);
    start_b = 1'b0;
    for (int k = 1; k <= 168; k++) begin
      @(negedge clk);
      if (dn8) begin n8++; if (t8 < 0) t8 = k; end
      if (dn4) begin n4++; if (t4 < 0) t4 = k; end
      if (dn1) begin n1++; if (t1 < 0) t1 = k; end
    end
    exp = ref_mul(a, b, f, MB);
    chk(c8 == exp, {req, " R3"}, "d8 product", c8, exp);
    chk(c4 == exp, {req, " R3"}, "d4 product", c4, exp);
    chk(c1 == exp, {req, " R2"}, "d1 product", c1, exp);
    chk(t8 == 21 && n8 == 1, "R4", "d8 done cycle", MB'(t8), MB'(21));
    chk(t4 == 41 && n4 == 1, "R4", "d4 done cycle", MB'(t4), MB'(41));
    chk(t1 == 163 && n1 == 1, "R2", "d1 done cycle", MB'(t1), MB'(163));
  endtask

  task automatic run_small(input logic [MS-1:0] a, input logic [MS-1:0] b,
                           input logic [MS-1:0] f, input string req);
    int t = -1, n = 0;
    logic [MB-1:0] exp;
    @(negedge clk);
    a_s = a; b_s = b; f_s = f; start_s = 1'b1;
    @(negedge clk);
    start_s = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      if (dn_s) begin n++; if (t < 0) t = k; end
    end
    exp = ref_mul(MB'(a), MB'(b), MB'(f), MS);
    chk(MB'(c_s) == exp, req, "small product", MB'(c_s), exp);
    chk(t == 3 && n == 1, "R4", "small done cycle", MB'(t), MB'(3));
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [MB-1:0] f163, ra, rb, held8, held4, held1;
    f163 = MB'(8'hC9);
    repeat (3) @(negedge clk);
    // R7: reset state
    chk(c8 == '0 && !dn8, "R7", "reset d8", c8, '0);
    chk(c1 == '0 && !dn1, "R7", "reset d1", c1, '0);
    chk(MB'(c_s) == '0 && !dn_s, "R7", "reset small", MB'(c_s), '0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(c4 == '0 && !dn4, "R7", "idle after release d4", c4, '0);

    // R9 corner operands
    ra = rnd_big();
    run_big(MB'(1), ra, f163, "R9");
    run_big(ra, '0, f163, "R9");
    run_big('1, '1, f163, "R1");

    // R1 random products, R8 second polynomial
    for (int i = 0; i < 8; i++) begin
      ra = rnd_big();
      rb = rnd_big();
      run_big(ra, rb, f163, "R1");
      run_big(ra, rb, rnd_big(), "R8");
    end

    // R5: result held while inputs change without start
    held8 = c8; held4 = c4; held1 = c1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      a_b = rnd_big(); b_b = rnd_big(); f_b = rnd_big();
    end
    @(negedge clk);
    chk(c8 == held8, "R5", "d8 hold", c8, held8);
    chk(c4 == held4, "R5", "d4 hold", c4, held4);
    chk(c1 == held1, "R5", "d1 hold", c1, held1);

    // R3/R8 exhaustive small field, two polynomials
    for (int fi = 0; fi < 2; fi++) begin
      for (int a = 0; a < 32; a++) begin
        for (int b = 0; b < 32; b++) begin
          run_small(MS'(a), MS'(b), (fi == 0) ? 5'b00101 : 5'b01001,
                    (fi == 0) ? "R3" : "R8");
        end
      end
    end

    // R6: restart mid-operation
    begin
      int t = -1, n = 0;
      logic [MB-1:0] exp;
      @(negedge clk);
      a_s = 5'd3; b_s = 5'd7; f_s = 5'b00101; start_s = 1'b1;
      @(negedge clk);
      start_s = 1'b0;
      @(negedge clk);
      if (dn_s) n++;
      a_s = 5'd22; b_s = 5'd19; start_s = 1'b1;
      @(negedge clk);
      start_s = 1'b0;
      if (dn_s) n++;
      for (int k = 1; k <= 5; k++) begin
        @(negedge clk);
        if (dn_s) begin n++; if (t < 0) t = k; end
      end
      exp = ref_mul(MB'(22), MB'(19), MB'(5'b00101), MS);
      chk(MB'(c_s) == exp, "R6", "restart product", MB'(c_s), exp);
      chk(t == 3 && n == 1, "R6", "restart done cycle", MB'(t), MB'(3));
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule